// File: doc/BRIEF.md
# Split-Step Branch Resolution Unit

This block lets a branch be assembled from three independent operations instead of one. A prepare operation stores a destination address in one of several numbered target registers. A compare operation checks two operand values for equality and stores the single-bit outcome in one of several numbered predicate registers. A branch operation then names one target register and one predicate register. It redirects control to that target only when the predicate is set.

Because each piece is held in its own architectural register, a scheduler can place the address computation and the condition test wherever the machine has idle slots. The transfer itself costs only a register read and a select. One operation is accepted per cycle. The branch result (taken flag and next PC) is registered and appears in the cycle after the branch operation, flagged by a one-cycle valid pulse. Fetch, pipelining and the general register file are outside this block, so compare operands and the current PC arrive as inputs.

Top module: `prep_branch_unit`

## Requirements
- R1: After reset every target register holds 0, every predicate register holds 0, and `resValid`, `resTaken` and `resNextPc` are all 0.
- R2: With `opCode` = 2'b01 (prepare), target register `tgtSel` takes `tgtAddr` at the clock edge. The stored value is used by every later branch that names it, until it is overwritten.
- R3: With `opCode` = 2'b10 (compare), predicate register `predSel` takes 1 when `cmpA` equals `cmpB` and 0 otherwise, at the clock edge.
- R4: With `opCode` = 2'b11 (branch) and predicate `predSel` set, `resTaken` is 1 and `resNextPc` equals target register `tgtSel` in the following cycle.
- R5: With `opCode` = 2'b11 and predicate `predSel` clear, `resTaken` is 0 and `resNextPc` equals `pcIn + 4` modulo 2^32 in the following cycle.
- R6: `resValid` is 1 in exactly the cycle after a branch operation, and 0 in every other cycle.
- R7: A register that is not written keeps its value. A prepare leaves the other targets and all predicates unchanged, and a compare leaves the other predicates and all targets unchanged.
- R8: With `opCode` = 2'b00 (none), no register changes, and `resTaken` and `resNextPc` keep the values of the last branch.
- R9: A branch reads the predicate and target values stored before its own clock edge. A compare or prepare issued in the cycle just before a branch is visible to that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 2 | 00 none, 01 prepare, 10 compare, 11 branch |
| tgtSel | input | 2 | Target register index for prepare and branch |
| predSel | input | 2 | Predicate register index for compare and branch |
| tgtAddr | input | 32 | Address stored by prepare |
| cmpA | input | 32 | First compare operand |
| cmpB | input | 32 | Second compare operand |
| pcIn | input | 32 | PC of the current branch operation |
| resValid | output | 1 | One-cycle pulse after a branch operation |
| resTaken | output | 1 | Outcome of the last branch |
| resNextPc | output | 32 | Next PC computed by the last branch |

## Verification
A corrupted target or predicate register stays hidden until a branch names it. The fault then shows one cycle after that branch, either as a flipped `resTaken` or as a `resNextPc` that does not match. The random stream therefore issues branches over all index pairs at a high rate, so a bad stored value is exposed within a few operations of being written. A fault in op decode shows immediately: `resValid` pulses at the wrong time, or the held outputs move during an idle or non-branch cycle.

// File: rtl/prep_branch_pkg.sv
package prep_branch_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_PREPARE = 2'b01,
    OP_COMPARE = 2'b10,
    OP_BRANCH  = 2'b11
  } branchOp_e;

  typedef struct packed {
    logic wrTarget;
    logic wrPred;
    logic doBranch;
  } stepStrobe_t;

endpackage

// File: rtl/prep_branch_ctrl.sv
module prep_branch_ctrl
  import prep_branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opCode,
  output stepStrobe_t strobe,
  output logic        resValid
);

  branchOp_e opDec;
  logic      validQ;

  always_comb begin
    opDec  = branchOp_e'(opCode);
    strobe = '0;
    unique case (opDec)
      OP_PREPARE: strobe.wrTarget = 1'b1;
      OP_COMPARE: strobe.wrPred   = 1'b1;
      OP_BRANCH:  strobe.doBranch = 1'b1;
      default:    strobe          = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.doBranch;
  end

  assign resValid = validQ;

  // R6: at most one step strobe per cycle
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrTarget, strobe.wrPred, strobe.doBranch}));

  // R6: valid pulse tracks branch opcode one cycle later
  p_valid_follows_branch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 2'b11) |=> resValid);

  p_valid_only_branch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != 2'b11) |=> !resValid);

endmodule

// File: rtl/prep_branch_dpath.sv
module prep_branch_dpath
  import prep_branch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_TGT  = 4,
  parameter int NUM_PRED = 4,
  parameter int PC_STEP  = 4,
  localparam int TSEL_W  = (NUM_TGT  > 1) ? $clog2(NUM_TGT)  : 1,
  localparam int PSEL_W  = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobe_t       strobe,
  input  logic [TSEL_W-1:0] tgtSel,
  input  logic [PSEL_W-1:0] predSel,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [ADDR_W-1:0] cmpA,
  input  logic [ADDR_W-1:0] cmpB,
  input  logic [ADDR_W-1:0] pcIn,
  output logic              resTaken,
  output logic [ADDR_W-1:0] resNextPc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] tgtQ [NUM_TGT];
  logic [NUM_PRED-1:0] predQ;
  logic cmpEq;
  logic selPred;
  logic [ADDR_W-1:0] selTgt;
  logic [ADDR_W-1:0] fallPc;
  logic takenQ;
  logic [ADDR_W-1:0] nextQ;

  // Target register bank, one writer per entry
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic wrHit;
    assign wrHit = strobe.wrTarget && (tgtSel == TSEL_W'(t));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      tgtQ[t] <= '0;
      else if (wrHit) tgtQ[t] <= tgtAddr;
    end
  end

  assign cmpEq = (cmpA == cmpB);

  // Predicate bank, single-bit entries
  for (genvar p = 0; p < NUM_PRED; p++) begin : g_pred
    logic wrHit;
    assign wrHit = strobe.wrPred && (predSel == PSEL_W'(p));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      predQ[p] <= 1'b0;
      else if (wrHit) predQ[p] <= cmpEq;
    end
  end

  assign selPred = predQ[predSel];
  assign selTgt  = tgtQ[tgtSel];
  assign fallPc  = pcIn + STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenQ <= 1'b0;
      nextQ  <= '0;
    end else if (strobe.doBranch) begin
      takenQ <= selPred;
      nextQ  <= selPred ? selTgt : fallPc;
    end
  end

  assign resTaken  = takenQ;
  assign resNextPc = nextQ;

  // R3: compare stores equality outcome in the named predicate
  p_pred_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPred |=> (predQ[$past(predSel)] == ($past(cmpA) == $past(cmpB))));

  // R2: prepare stores address in the named target
  p_tgt_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTarget |=> (tgtQ[$past(tgtSel)] == $past(tgtAddr)));

  // R7: predicates untouched without a compare
  p_pred_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrPred |=> $stable(predQ));

  // R5: not-taken result is fall-through address
  p_fall_through_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doBranch && !selPred) |=> (!resTaken && resNextPc == $past(pcIn) + STEP));

  // R4: taken result is the stored target
  p_taken_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doBranch && selPred) |=> (resTaken && resNextPc == $past(selTgt)));

  // R8: outputs hold between branches
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doBranch |=> ($stable(resTaken) && $stable(resNextPc)));

endmodule

// File: rtl/prep_branch_unit.sv
module prep_branch_unit
  import prep_branch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_TGT  = 4,
  parameter int NUM_PRED = 4,
  parameter int PC_STEP  = 4,
  localparam int TSEL_W  = (NUM_TGT  > 1) ? $clog2(NUM_TGT)  : 1,
  localparam int PSEL_W  = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opCode,
  input  logic [TSEL_W-1:0] tgtSel,
  input  logic [PSEL_W-1:0] predSel,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [ADDR_W-1:0] cmpA,
  input  logic [ADDR_W-1:0] cmpB,
  input  logic [ADDR_W-1:0] pcIn,
  output logic              resValid,
  output logic              resTaken,
  output logic [ADDR_W-1:0] resNextPc
);

  stepStrobe_t strobe;

  prep_branch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opCode   (opCode),
    .strobe   (strobe),
    .resValid (resValid)
  );

  prep_branch_dpath #(
    .ADDR_W   (ADDR_W),
    .NUM_TGT  (NUM_TGT),
    .NUM_PRED (NUM_PRED),
    .PC_STEP  (PC_STEP)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tgtSel    (tgtSel),
    .predSel   (predSel),
    .tgtAddr   (tgtAddr),
    .cmpA      (cmpA),
    .cmpB      (cmpB),
    .pcIn      (pcIn),
    .resTaken  (resTaken),
    .resNextPc (resNextPc)
  );

  // R6: no result pulse in back-to-back cycles unless branches were back to back
  p_valid_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(resValid)) |-> ($past(opCode, 2) == 2'b11));

endmodule

// File: tb/sim_prep_branch_unit.sv
module sim_prep_branch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [1:0]  tgtSel = '0;
  logic [1:0]  predSel = '0;
  logic [31:0] tgtAddr = '0;
  logic [31:0] cmpA = '0;
  logic [31:0] cmpB = '0;
  logic [31:0] pcIn = '0;
  logic        resValid;
  logic        resTaken;
  logic [31:0] resNextPc;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] tgtM [4];
  logic [3:0]  predM;
  logic        heldTaken;
  logic [31:0] heldNext;

  always #2.5 clk = ~clk;

  prep_branch_unit u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .tgtSel(tgtSel), .predSel(predSel),
    .tgtAddr(tgtAddr), .cmpA(cmpA), .cmpB(cmpB), .pcIn(pcIn),
    .resValid(resValid), .resTaken(resTaken), .resNextPc(resNextPc)
  );

  function automatic logic [31:0] expNext(logic taken, logic [31:0] tgt, logic [31:0] pc);
    return taken ? tgt : pc + 32'd4;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation: drive at negedge, sample 1 ns after the capturing edge
  task automatic doOp(logic [1:0] op, logic [1:0] ts, logic [1:0] ps,
                      logic [31:0] addr, logic [31:0] a, logic [31:0] b, logic [31:0] pc);
    string tag;
    @(negedge clk);
    opCode = op; tgtSel = ts; predSel = ps; tgtAddr = addr; cmpA = a; cmpB = b; pcIn = pc;
    @(posedge clk);
    #1;
    if (op == 2'b11) begin
      heldTaken = predM[ps];
      heldNext  = expNext(predM[ps], tgtM[ts], pc);
      tag = heldTaken ? "R4" : "R5";
    end else begin
      tag = "R8";
    end
    check("R6 valid", {31'd0, resValid}, {31'd0, op == 2'b11});
    check({tag, " taken"}, {31'd0, resTaken}, {31'd0, heldTaken});
    check({tag, " nextPc"}, resNextPc, heldNext);
    if (op == 2'b01) tgtM[ts] = addr;
    if (op == 2'b10) predM[ps] = (a == b);
  endtask

  initial begin
    #(5 * 150000);
    $display("FAIL watchdog: actual=running expected=done");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) tgtM[i] = '0;
    predM = '0; heldTaken = 1'b0; heldNext = '0;

    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", {31'd0, resValid}, 32'd0);
    check("R1 taken", {31'd0, resTaken}, 32'd0);
    check("R1 nextPc", resNextPc, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: fresh predicates clear, fall through
    for (int k = 0; k < 4; k++) doOp(2'b11, 2'(k), 2'(k), '0, '0, '0, 32'h100 + 32'(k));
    // R2 R5: prepare then branch on clear predicate
    doOp(2'b01, 2'd2, 2'd0, 32'h0000_4000, '0, '0, '0);
    doOp(2'b11, 2'd2, 2'd1, '0, '0, '0, 32'h2000);
    // R3 R4 R9: compare equal then branch next cycle
    doOp(2'b10, 2'd0, 2'd1, '0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, '0);
    doOp(2'b11, 2'd2, 2'd1, '0, '0, '0, 32'h2004);
    // R4: reset-valued target 0 taken to address 0
    doOp(2'b11, 2'd0, 2'd1, '0, '0, '0, 32'h3000);
    // R3: unequal clears predicate
    doOp(2'b10, 2'd0, 2'd1, '0, 32'h1, 32'h3, '0);
    doOp(2'b11, 2'd2, 2'd1, '0, '0, '0, 32'h2008);
    // R5: wrap of pc + 4
    doOp(2'b11, 2'd2, 2'd3, '0, '0, '0, 32'hFFFF_FFFC);
    // R7: write other target, branch on old one
    doOp(2'b10, 2'd0, 2'd3, '0, 32'h7, 32'h7, '0);
    doOp(2'b01, 2'd1, 2'd0, 32'hAAAA_0000, '0, '0, '0);
    doOp(2'b11, 2'd2, 2'd3, '0, '0, '0, 32'h10);
    // R8: idle cycles hold outputs
    doOp(2'b00, 2'd1, 2'd3, 32'h1234, 32'h5, 32'h5, 32'h77);
    doOp(2'b00, 2'd3, 2'd2, 32'h9999, 32'h6, 32'h6, 32'h88);
    doOp(2'b11, 2'd3, 2'd2, '0, '0, '0, 32'h40);

    // Random mix, branches frequent
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      logic [31:0] a;
      logic [31:0] b;
      op = 2'($urandom_range(0, 3));
      a  = 32'($urandom_range(0, 7));
      b  = ($urandom_range(0, 1) == 0) ? a : 32'($urandom_range(0, 7));
      doOp(op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           $urandom & 32'hFFFF_FFFC, a, b, $urandom & 32'hFFFF_FFFC);
    end

    // R9: register values reached through branches after random traffic
    for (int k = 0; k < 4; k++) doOp(2'b11, 2'(k), 2'(k), '0, '0, '0, 32'h500);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule